// File: doc/BRIEF.md
# Mixed-Sign Multiply-Accumulate with Convergent Read-Out

This block is the multiply-accumulate datapath of a fixed-point audio processor. Each clock it can multiply two 20-bit operands and load the product into a 48-bit accumulator, add the product to it, or subtract the product from it. A two-bit signedness selector sets how each operand is read: both unsigned, the first signed and the second unsigned, or both signed. Software can also clear the accumulator or load it with an arbitrary value.

The accumulator drives a combinational read-out path. This path drops a parameterised number of low bits with round-half-to-even, then clamps the result to a narrower two's-complement sample word. The default word is 24 bits, which is enough for high-resolution PCM. Whenever the limiter clamps, a live flag is raised. A sticky copy of that flag records the event until the accumulator is cleared.

Top module: `mixmac_core`

## Requirements
- R1: After reset the accumulator is zero, the sample output is zero, and both saturation flags are low.
- R2: The op field is decoded as follows: 2'b00 holds the accumulator, 2'b01 loads the product, 2'b10 adds the product and 2'b11 subtracts it. Each takes effect at the next rising clock edge.
- R3: The signedness field is decoded as follows: 2'b00 reads both operands as unsigned, 2'b01 reads operand A as signed and operand B as unsigned, and 2'b10 and 2'b11 read both as signed.
- R4: Clear has priority over load, and load has priority over the op field. Clear zeroes both the accumulator and the sticky flag.
- R5: When load is high and clear is low, the accumulator takes the load value at the next edge.
- R6: Accumulator arithmetic wraps modulo 2^ACCW.
- R7: The sample is the accumulator shifted right arithmetically by DROP bits. It is incremented when the dropped bits exceed one half.
- R8: When the dropped bits equal exactly one half, the sample is incremented only if the kept field is odd, so an exact half rounds to the even neighbour.
- R9: A rounded value above the largest OUTW-bit code gives that code. A value below the smallest code gives that code. Either case raises the live saturation flag.
- R10: The sticky flag goes high at the clock edge after the live flag is seen high, and stays high until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clear accumulator and sticky flag |
| ld | input | 1 | Load accumulator from ld_val |
| ld_val | input | ACCW | Value to load |
| op | input | 2 | Hold / load product / add / subtract |
| mode | input | 2 | Operand signedness selector |
| opa | input | OPW | Operand A |
| opb | input | OPW | Operand B |
| acc_q | output | ACCW | Full accumulator value |
| smp_out | output | OUTW | Rounded and limited sample |
| sat_now | output | 1 | Limiter is clamping the current value |
| sat_sticky | output | 1 | Limiter has clamped since the last clear |

## Verification
The bench builds the block with OPW=20, ACCW=48 and OUTW=24, and lowers DROP to 8. With a small drop, an exact half and the even/odd decision can be set directly through the load port with short values. With a full 20x20 product shifted right by only 8, the result far exceeds the 24-bit range, so both limits and the sticky flag are reachable from ordinary multiplies. One loaded value rounds up across the positive limit, which checks that limiting is applied after rounding.

// File: rtl/mixmac_pkg.sv
// Shared encodings for the multiply-accumulate datapath.
package mixmac_pkg;

    // Accumulator operation selected by the op field.
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_MPY  = 2'b01,
        OP_MAC  = 2'b10,
        OP_MSU  = 2'b11
    } mac_op_e;

    // Operand signedness; code 2'b11 behaves as SGN_SS.
    typedef enum logic [1:0] {
        SGN_UU = 2'b00,
        SGN_SU = 2'b01,
        SGN_SS = 2'b10,
        SGN_SX = 2'b11
    } sgn_mode_e;

    // Returns 1 when operand A is read as signed.
    function automatic logic a_is_signed(input sgn_mode_e m);
        return (m != SGN_UU);
    endfunction

    // Returns 1 when operand B is read as signed.
    function automatic logic b_is_signed(input sgn_mode_e m);
        return (m == SGN_SS) || (m == SGN_SX);
    endfunction

endpackage

// File: rtl/mixmac_mul.sv
// Operand extension and product.
// Assumes: each operand is widened by one bit (a sign bit or a zero)
// according to the mode, so one signed multiplier covers all modes.
module mixmac_mul #(
    parameter int OPW = 20,
    parameter int PW  = 2 * OPW + 2
) (
    input  logic [OPW-1:0]        a,
    input  logic [OPW-1:0]        b,
    input  logic [1:0]            mode,
    output logic signed [PW-1:0]  prod
);
    import mixmac_pkg::*;

    logic              a_sgn, b_sgn;
    logic [OPW:0]      a_x, b_x;
    logic signed [PW-1:0] a_w, b_w;

    // Decode the signedness of each operand.
    always_comb begin
        a_sgn = a_is_signed(sgn_mode_e'(mode));
        b_sgn = b_is_signed(sgn_mode_e'(mode));
    end

    // Add one top bit per operand: a copy of the MSB if signed, otherwise zero.
    always_comb begin
        a_x = {a_sgn & a[OPW-1], a};
        b_x = {b_sgn & b[OPW-1], b};
    end

    // Sign-extend to product width and multiply (the exact product fits in PW).
    always_comb begin
        a_w  = {{(PW-OPW-1){a_x[OPW]}}, a_x};
        b_w  = {{(PW-OPW-1){b_x[OPW]}}, b_x};
        prod = a_w * b_w;
    end
endmodule

// File: rtl/mixmac_acc.sv
// Accumulator register with clear, load and product ops.
// Assumes: PW <= ACCW; arithmetic wraps modulo 2^ACCW.
module mixmac_acc #(
    parameter int ACCW = 48,
    parameter int PW   = 42
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 ld,
    input  logic [ACCW-1:0]      ld_val,
    input  logic [1:0]           op,
    input  logic signed [PW-1:0] prod,
    output logic [ACCW-1:0]      acc
);
    import mixmac_pkg::*;

    logic [ACCW-1:0] prod_x;
    logic [ACCW-1:0] acc_nx;

    // Sign-extend the product to accumulator width.
    always_comb prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};

    // Select the next accumulator value: clear, then load, then op.
    always_comb begin
        acc_nx = acc;
        if (clr) begin
            acc_nx = '0;
        end else if (ld) begin
            acc_nx = ld_val;
        end else begin
            case (mac_op_e'(op))
                OP_MPY:  acc_nx = prod_x;
                OP_MAC:  acc_nx = acc + prod_x;
                OP_MSU:  acc_nx = acc - prod_x;
                default: acc_nx = acc;
            endcase
        end
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc_nx;
    end
endmodule

// File: rtl/mixmac_rndlim.sv
// Convergent rounding and saturating limiter.
// Assumes: DROP >= 1 and ACCW - DROP >= OUTW.
module mixmac_rndlim #(
    parameter int ACCW = 48,
    parameter int DROP = 20,
    parameter int OUTW = 24
) (
    input  logic [ACCW-1:0] acc,
    output logic [OUTW-1:0] smp,
    output logic            sat
);
    localparam int KW = ACCW - DROP;
    localparam int RW = KW + 1;
    localparam logic [DROP-1:0]     HALF = DROP'(1) << (DROP - 1);
    localparam logic signed [RW-1:0] MAXV = RW'((64'sd1 <<< (OUTW - 1)) - 64'sd1);
    localparam logic signed [RW-1:0] MINV = -MAXV - RW'(1);

    logic [KW-1:0]        kept;
    logic [DROP-1:0]      low;
    logic                 up;
    logic signed [RW-1:0] rnd;
    logic                 hi, lo;

    // Split the accumulator into the kept field and the dropped bits.
    always_comb begin
        kept = acc[ACCW-1:DROP];
        low  = acc[DROP-1:0];
    end

    // Round up above one half; on an exact half, round up only when the kept field is odd.
    always_comb up = (low > HALF) || ((low == HALF) && kept[0]);

    // Add the rounding increment one bit wider so it cannot overflow.
    always_comb rnd = $signed({kept[KW-1], kept}) + $signed({{(RW-1){1'b0}}, up});

    // Clamp to the OUTW-bit code range.
    always_comb begin
        hi  = rnd > MAXV;
        lo  = rnd < MINV;
        sat = hi || lo;
        if (hi)      smp = MAXV[OUTW-1:0];
        else if (lo) smp = MINV[OUTW-1:0];
        else         smp = rnd[OUTW-1:0];
    end
endmodule

// File: rtl/mixmac_core.sv
// Top level: multiplier, accumulator, read-out path and sticky flag.
// Assumes: the read-out path is combinational from the accumulator register.
module mixmac_core #(
    parameter int OPW  = 20,
    parameter int ACCW = 48,
    parameter int DROP = 20,
    parameter int OUTW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            ld,
    input  logic [ACCW-1:0] ld_val,
    input  logic [1:0]      op,
    input  logic [1:0]      mode,
    input  logic [OPW-1:0]  opa,
    input  logic [OPW-1:0]  opb,
    output logic [ACCW-1:0] acc_q,
    output logic [OUTW-1:0] smp_out,
    output logic            sat_now,
    output logic            sat_sticky
);
    localparam int PW = 2 * OPW + 2;

    logic signed [PW-1:0] prod;

    mixmac_mul #(.OPW(OPW), .PW(PW)) u_mul (
        .a    (opa),
        .b    (opb),
        .mode (mode),
        .prod (prod)
    );

    mixmac_acc #(.ACCW(ACCW), .PW(PW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .ld     (ld),
        .ld_val (ld_val),
        .op     (op),
        .prod   (prod),
        .acc    (acc_q)
    );

    mixmac_rndlim #(.ACCW(ACCW), .DROP(DROP), .OUTW(OUTW)) u_rnd (
        .acc (acc_q),
        .smp (smp_out),
        .sat (sat_now)
    );

    // Sticky saturation flag, cleared by clr.
    always_ff @(posedge clk) begin
        if (!rst_n)   sat_sticky <= 1'b0;
        else if (clr) sat_sticky <= 1'b0;
        else if (sat_now) sat_sticky <= 1'b1;
    end
endmodule

// File: rtl/mixmac_core_chk.sv
// Property checker bound to mixmac_core.
module mixmac_core_chk #(
    parameter int ACCW = 48,
    parameter int OUTW = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            ld,
    input logic [ACCW-1:0] ld_val,
    input logic [1:0]      op,
    input logic [ACCW-1:0] acc_q,
    input logic [OUTW-1:0] smp_out,
    input logic            sat_now,
    input logic            sat_sticky
);
    localparam logic [OUTW-1:0] MAXC = {1'b0, {(OUTW-1){1'b1}}};
    localparam logic [OUTW-1:0] MINC = {1'b1, {(OUTW-1){1'b0}}};

    p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0) && !sat_sticky);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && op == 2'b00) |=> $stable(acc_q));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> acc_q == $past(ld_val));

    p_sat_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sat_now |-> (smp_out == MAXC || smp_out == MINC));

    p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && sat_now) |=> sat_sticky);

    p_sticky_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !clr) |=> sat_sticky);
endmodule

bind mixmac_core mixmac_core_chk #(.ACCW(ACCW), .OUTW(OUTW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .ld         (ld),
    .ld_val     (ld_val),
    .op         (op),
    .acc_q      (acc_q),
    .smp_out    (smp_out),
    .sat_now    (sat_now),
    .sat_sticky (sat_sticky)
);

// File: tb/mixmac_core_tb.sv
module mixmac_core_tb;
    localparam int OPW  = 20;
    localparam int ACCW = 48;
    localparam int DROP = 8;
    localparam int OUTW = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr = 1'b0;
    logic            ld = 1'b0;
    logic [ACCW-1:0] ld_val = '0;
    logic [1:0]      op = 2'b00;
    logic [1:0]      mode = 2'b00;
    logic [OPW-1:0]  opa = '0;
    logic [OPW-1:0]  opb = '0;
    logic [ACCW-1:0] acc_q;
    logic [OUTW-1:0] smp_out;
    logic            sat_now;
    logic            sat_sticky;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    longint model = 0;

    always #2.5 clk = ~clk;

    mixmac_core #(.OPW(OPW), .ACCW(ACCW), .DROP(DROP), .OUTW(OUTW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .ld_val(ld_val),
        .op(op), .mode(mode), .opa(opa), .opb(opb), .acc_q(acc_q),
        .smp_out(smp_out), .sat_now(sat_now), .sat_sticky(sat_sticky)
    );

    function automatic longint wrap48(longint v);
        longint r;
        r = v <<< 16;
        return r >>> 16;
    endfunction

    function automatic longint ext20(logic [OPW-1:0] v, bit sgn);
        longint r;
        r = longint'(v);
        if (sgn && v[OPW-1]) r = r - (64'sd1 <<< OPW);
        return r;
    endfunction

    function automatic longint exp_smp(longint a, output bit sat);
        longint kept, low, r, mx, mn;
        kept = a >>> DROP;
        low  = a & ((64'sd1 <<< DROP) - 1);
        r = kept;
        if (low > (64'sd1 <<< (DROP-1))) r = kept + 1;
        else if (low == (64'sd1 <<< (DROP-1)) && kept[0]) r = kept + 1;
        mx = (64'sd1 <<< (OUTW-1)) - 1;
        mn = -mx - 1;
        sat = 0;
        if (r > mx) begin r = mx; sat = 1; end
        else if (r < mn) begin r = mn; sat = 1; end
        return r;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Compare accumulator, sample and live flag with the model.
    task automatic chk_all(string tag);
        bit s;
        longint e;
        e = exp_smp(model, s);
        chk({tag, " acc"}, wrap48(longint'(acc_q)), model);
        chk({tag, " smp"}, longint'($signed(smp_out)), e);
        chk({tag, " sat"}, longint'(sat_now), longint'(s));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clr = 0; ld = 0; op = 2'b00;
    endtask

    task automatic do_op(logic [1:0] o, logic [1:0] m, logic [OPW-1:0] a, logic [OPW-1:0] b);
        longint p;
        op = o; mode = m; opa = a; opb = b;
        p = ext20(a, m != 2'b00) * ext20(b, m[1]);
        case (o)
            2'b01: model = wrap48(p);
            2'b10: model = wrap48(model + p);
            2'b11: model = wrap48(model - p);
            default: ;
        endcase
        step();
    endtask

    task automatic do_ld(longint v);
        ld = 1; ld_val = v[ACCW-1:0];
        model = wrap48(v);
        step();
    endtask

    task automatic do_clr();
        clr = 1; model = 0;
        step();
    endtask

    task automatic t_reset();
        chk("R1 acc", longint'(acc_q), 0);
        chk("R1 smp", longint'(smp_out), 0);
        chk("R1 sat", longint'(sat_now), 0);
        chk("R1 sticky", longint'(sat_sticky), 0);
    endtask

    task automatic t_modes();
        do_op(2'b01, 2'b00, 20'hFFFFF, 20'hFFFFF); chk_all("R3 uu");
        chk("R3 uu value", model, 64'hFF_FFE0_0001);
        do_op(2'b01, 2'b01, 20'hFFFFF, 20'hFFFFF); chk_all("R3 su");
        chk("R3 su value", model, -64'sd1048575);
        do_op(2'b01, 2'b10, 20'hFFFFF, 20'hFFFFF); chk_all("R3 ss");
        do_op(2'b01, 2'b11, 20'h80000, 20'h7FFFF); chk_all("R3 mode3");
    endtask

    task automatic t_mac_msu();
        do_op(2'b01, 2'b10, 20'd3000, 20'd500); chk_all("R2 mpy");
        do_op(2'b10, 2'b10, 20'hFFFF9, 20'd200); chk_all("R2 mac");
        do_op(2'b11, 2'b10, 20'd40, 20'd1000); chk_all("R2 msu");
        do_op(2'b00, 2'b10, 20'd77, 20'd77); chk_all("R2 hold");
    endtask

    task automatic t_ld_clr();
        do_ld(64'sh1234_5678); chk_all("R5 load");
        clr = 1; ld = 1; ld_val = 48'h1; op = 2'b01; opa = 5; opb = 5; model = 0;
        step(); chk_all("R4 clr priority");
        ld = 1; ld_val = 48'h100; op = 2'b10; opa = 5; opb = 5; model = 64'sh100;
        step(); chk_all("R4 ld over op");
    endtask

    task automatic t_wrap();
        do_ld(64'sh7FFF_FFFF_FFFF);
        do_op(2'b10, 2'b00, 20'd1, 20'd1); chk_all("R6 wrap");
        chk("R6 wrap value", model, -(64'sd1 <<< 47));
        do_clr();
    endtask

    task automatic t_round();
        do_ld(64'sh280); chk_all("R8 half even down");
        chk("R8 half even value", longint'($signed(smp_out)), 2);
        do_ld(64'sh180); chk_all("R8 half odd up");
        chk("R8 half odd value", longint'($signed(smp_out)), 2);
        do_ld(64'sh281); chk_all("R7 above half");
        do_ld(64'sh27F); chk_all("R7 below half");
        do_ld(-64'sh80); chk_all("R8 neg half");
        chk("R8 neg half value", longint'($signed(smp_out)), 0);
        do_ld(-64'sh181); chk_all("R7 neg below");
    endtask

    task automatic t_sat();
        do_clr();
        do_ld(64'sh7FFF_FF80); chk_all("R9 round into limit");
        chk("R9 max code", longint'(smp_out), 64'h7F_FFFF);
        chk("R10 sticky not yet", longint'(sat_sticky), 0);
        do_ld(64'sh0); chk("R10 sticky set", longint'(sat_sticky), 1);
        do_ld(64'sh10); chk("R10 sticky held", longint'(sat_sticky), 1);
        do_clr(); chk("R4 clr sticky", longint'(sat_sticky), 0);
        do_op(2'b01, 2'b10, 20'h80000, 20'h7FFFF); chk_all("R9 neg limit");
        chk("R9 min code", longint'(smp_out), 64'h80_0000);
        do_op(2'b01, 2'b00, 20'hFFFFF, 20'hFFFFF); chk_all("R9 pos limit mpy");
        do_op(2'b00, 2'b00, 20'h0, 20'h0);
        chk("R10 sticky after mpy", longint'(sat_sticky), 1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_mac_msu();
        t_ld_clr();
        t_wrap();
        t_round();
        t_sat();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule